// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor that executes each instruction over several short clock cycles. It uses separate instruction and data memories. A 4-bit state register steps through fetch, decode and one short path for each instruction class. Every enable and select that the datapath needs comes from the current state alone. The one exception is the ALU operation in the register-register execute step, which the function field chooses.

The block handles five instruction classes: register-register, OR with an immediate, load word, store word and branch-on-equal. The program counter is written exactly once per instruction, in the last cycle of that instruction. It takes the sequential address in every case except a taken branch. The cycle counts are 4 for register-register, OR-immediate and store, 5 for load, and 3 for branch. An opcode outside the supported set spends only fetch and decode and writes nothing.

All pins are plain control and status signals. No data moves through the block, so it has no valid/ready handshake. The surrounding datapath samples the enables on the same rising edge that moves the state register.

Top module: `cyc_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in the fetch state (code 0000) on the next rising edge, from any state. While `rst` is held, the outputs show fetch.
- R2: Fetch asserts only `imem_rd` and `ir_en`. The next cycle is always decode (0001), which asserts only `a_en` and `b_en`.
- R3: Outside decode, `opcode` and `eq_flag` have no effect on outputs or on sequencing. `funct` affects only `alu_op` in the register-register execute state.
- R4: Opcode 000000 (register-register): the execute cycle asserts `res_en` with `alu_op` taken from `funct`. The next cycle asserts `rf_wr`, `dst_rd`=1, `wb_mem`=0 and `pc_en` with `pc_sel`=0. The instruction takes 4 cycles.
- R5: Opcode 001101 (OR-immediate): the execute cycle asserts `res_en` with `alu_op`=OR. The next cycle asserts `rf_wr`, `dst_rd`=0 and `pc_en` with `pc_sel`=0. The instruction takes 4 cycles.
- R6: Opcode 100011 (load): address cycle with `res_en` and `alu_op`=ADD, then a cycle with `dmem_rd`, then a cycle with `rf_wr`, `wb_mem`=1, `dst_rd`=0 and `pc_en` with `pc_sel`=0. The instruction takes 5 cycles.
- R7: Opcode 101011 (store): address cycle with `res_en` and `alu_op`=ADD, then a cycle with `dmem_wr` and `pc_en` with `pc_sel`=0. The instruction takes 4 cycles.
- R8: Opcode 000100 with `eq_flag`=1 at the end of decode: the third cycle asserts `pc_en` with `pc_sel`=1, then fetch follows.
- R9: Opcode 000100 with `eq_flag`=0: the third cycle asserts `pc_en` with `pc_sel`=0, then fetch follows.
- R10: Any other opcode returns from decode straight to fetch. It asserts no register, memory or PC write.
- R11: `alu_op` encoding: ADD=0, SUB=1, AND=2, OR=3, SLT=4. In the register-register execute state, funct 100000→ADD, 100010→SUB, 100100→AND, 100101→OR, 101010→SLT, and any other value→ADD. Every state other than the two execute states that pick an operation drives ADD.
- R12: `pc_en` is high in exactly one cycle per supported instruction, the last one, and fetch always follows it. `rf_wr`, `dmem_rd` and `dmem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| eq_flag | input | 1 | Operands-equal condition from the datapath |
| imem_rd | output | 1 | Instruction memory read |
| ir_en | output | 1 | Instruction register load |
| a_en | output | 1 | Operand A register load |
| b_en | output | 1 | Operand B register load |
| alu_op | output | 3 | ALU operation (encoding in R11) |
| res_en | output | 1 | ALU result register load |
| dmem_rd | output | 1 | Data memory read into memory data register |
| dmem_wr | output | 1 | Data memory write of operand B |
| rf_wr | output | 1 | Register file write |
| dst_rd | output | 1 | Destination is rd field (1) or rt field (0) |
| wb_mem | output | 1 | Write-back data from memory register (1) or result register (0) |
| pc_en | output | 1 | Program counter load |
| pc_sel | output | 1 | PC source: branch target (1) or PC+4 (0) |

## Verification
The hardest property to reach from the ports is R3: only the decode cycle may look at the opcode and the condition flag. A wrong dependency hides unless those inputs change in every other cycle. The stimulus therefore drives fresh random opcode, flag and function values in every cycle except decode, and except the execute step of a register-register instruction for `funct`. It also interleaves instructions so that every state hands over to a different next instruction. A directed reset in the middle of a load checks the return to fetch from a memory state.

// File: rtl/cyc_ctrl_pkg.sv
package cyc_ctrl_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int ST_W  = 4;
  localparam int ALU_W = 3;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'b0000,
    S_DEC    = 4'b0001,
    S_BR_NT  = 4'b0010,
    S_BR_TK  = 4'b0011,
    S_R_EX   = 4'b0100,
    S_R_WB   = 4'b0101,
    S_OI_EX  = 4'b0110,
    S_OI_WB  = 4'b0111,
    S_LD_EX  = 4'b1000,
    S_LD_MEM = 4'b1001,
    S_LD_WB  = 4'b1010,
    S_ST_EX  = 4'b1011,
    S_ST_MEM = 4'b1100
  } state_e;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OPC_LW    = 6'b100011;
  localparam logic [OP_W-1:0] OPC_SW    = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_e;

  typedef enum logic [1:0] {
    ASEL_ADD = 2'd0,
    ASEL_OR  = 2'd1,
    ASEL_FN  = 2'd2
  } asel_e;

  typedef struct packed {
    logic  imem_rd;
    logic  ir_en;
    logic  a_en;
    logic  b_en;
    asel_e alu_sel;
    logic  res_en;
    logic  dmem_rd;
    logic  dmem_wr;
    logic  rf_wr;
    logic  dst_rd;
    logic  wb_mem;
    logic  pc_en;
    logic  pc_sel;
  } ctrl_t;
endpackage

// File: rtl/cyc_ctrl_next.sv
module cyc_ctrl_next
  import cyc_ctrl_pkg::*;
(
  input  state_e          cur,
  input  logic [OP_W-1:0] opcode,
  input  logic            eq_flag,
  output state_e          nxt
);
  // Only the decode state looks at opcode and condition.
  always_comb begin
    nxt = S_FETCH;
    unique case (cur)
      S_FETCH:  nxt = S_DEC;
      S_DEC: begin
        case (opcode)
          OPC_RTYPE: nxt = S_R_EX;
          OPC_ORI:   nxt = S_OI_EX;
          OPC_LW:    nxt = S_LD_EX;
          OPC_SW:    nxt = S_ST_EX;
          OPC_BEQ:   nxt = eq_flag ? S_BR_TK : S_BR_NT;
          default:   nxt = S_FETCH;
        endcase
      end
      S_R_EX:   nxt = S_R_WB;
      S_OI_EX:  nxt = S_OI_WB;
      S_LD_EX:  nxt = S_LD_MEM;
      S_LD_MEM: nxt = S_LD_WB;
      S_ST_EX:  nxt = S_ST_MEM;
      default:  nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/cyc_ctrl_outs.sv
module cyc_ctrl_outs
  import cyc_ctrl_pkg::*;
(
  input  state_e cur,
  output ctrl_t  ctl
);
  // Moore output table: one row per state, everything else low.
  always_comb begin
    ctl = '0;
    ctl.alu_sel = ASEL_ADD;
    case (cur)
      S_FETCH: begin ctl.imem_rd = 1'b1; ctl.ir_en = 1'b1; end
      S_DEC:   begin ctl.a_en = 1'b1; ctl.b_en = 1'b1; end
      S_BR_NT: begin ctl.pc_en = 1'b1; end
      S_BR_TK: begin ctl.pc_en = 1'b1; ctl.pc_sel = 1'b1; end
      S_R_EX:  begin ctl.alu_sel = ASEL_FN; ctl.res_en = 1'b1; end
      S_R_WB:  begin ctl.rf_wr = 1'b1; ctl.dst_rd = 1'b1; ctl.pc_en = 1'b1; end
      S_OI_EX: begin ctl.alu_sel = ASEL_OR; ctl.res_en = 1'b1; end
      S_OI_WB: begin ctl.rf_wr = 1'b1; ctl.pc_en = 1'b1; end
      S_LD_EX, S_ST_EX: ctl.res_en = 1'b1;
      S_LD_MEM: ctl.dmem_rd = 1'b1;
      S_LD_WB: begin ctl.rf_wr = 1'b1; ctl.wb_mem = 1'b1; ctl.pc_en = 1'b1; end
      S_ST_MEM: begin ctl.dmem_wr = 1'b1; ctl.pc_en = 1'b1; end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/cyc_ctrl_alu.sv
module cyc_ctrl_alu
  import cyc_ctrl_pkg::*;
(
  input  asel_e           sel,
  input  logic [FN_W-1:0] funct,
  output alu_e            op
);
  always_comb begin
    op = ALU_ADD;
    case (sel)
      ASEL_OR: op = ALU_OR;
      ASEL_FN: begin
        case (funct)
          FN_SUB:  op = ALU_SUB;
          FN_AND:  op = ALU_AND;
          FN_OR:   op = ALU_OR;
          FN_SLT:  op = ALU_SLT;
          default: op = ALU_ADD;
        endcase
      end
      default: op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/cyc_ctrl.sv
module cyc_ctrl
  import cyc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             eq_flag,
  output logic             imem_rd,
  output logic             ir_en,
  output logic             a_en,
  output logic             b_en,
  output logic [ALU_W-1:0] alu_op,
  output logic             res_en,
  output logic             dmem_rd,
  output logic             dmem_wr,
  output logic             rf_wr,
  output logic             dst_rd,
  output logic             wb_mem,
  output logic             pc_en,
  output logic             pc_sel
);
  state_e cur, nxt;
  ctrl_t  ctl;
  alu_e   op;

  always_ff @(posedge clk) begin
    if (rst) cur <= S_FETCH;
    else     cur <= nxt;
  end

  cyc_ctrl_next u_next (.cur(cur), .opcode(opcode), .eq_flag(eq_flag), .nxt(nxt));
  cyc_ctrl_outs u_outs (.cur(cur), .ctl(ctl));
  cyc_ctrl_alu  u_alu  (.sel(ctl.alu_sel), .funct(funct), .op(op));

  assign imem_rd = ctl.imem_rd;
  assign ir_en   = ctl.ir_en;
  assign a_en    = ctl.a_en;
  assign b_en    = ctl.b_en;
  assign alu_op  = op;
  assign res_en  = ctl.res_en;
  assign dmem_rd = ctl.dmem_rd;
  assign dmem_wr = ctl.dmem_wr;
  assign rf_wr   = ctl.rf_wr;
  assign dst_rd  = ctl.dst_rd;
  assign wb_mem  = ctl.wb_mem;
  assign pc_en   = ctl.pc_en;
  assign pc_sel  = ctl.pc_sel;

  logic dec_known;
  assign dec_known = (opcode == OPC_RTYPE) || (opcode == OPC_ORI) || (opcode == OPC_LW) ||
                     (opcode == OPC_SW) || (opcode == OPC_BEQ);

  p_rst_fetch_r1: assert property (@(posedge clk) rst |=> (imem_rd && ir_en && !pc_en));
  p_fetch_dec_r2: assert property (@(posedge clk) disable iff (rst)
    ir_en |=> (a_en && b_en && !ir_en));
  p_br_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (a_en && opcode == OPC_BEQ && eq_flag) |=> (pc_en && pc_sel));
  p_br_not_r9: assert property (@(posedge clk) disable iff (rst)
    (a_en && opcode == OPC_BEQ && !eq_flag) |=> (pc_en && !pc_sel));
  p_unknown_r10: assert property (@(posedge clk) disable iff (rst)
    (a_en && !dec_known) |=> (ir_en && !rf_wr && !dmem_wr && !pc_en));
  p_ld_wb_r6: assert property (@(posedge clk) disable iff (rst)
    dmem_rd |=> (rf_wr && wb_mem && !dst_rd && pc_en && !pc_sel));
  p_st_mem_r7: assert property (@(posedge clk) disable iff (rst)
    (a_en && opcode == OPC_SW) |=> ##1 (dmem_wr && pc_en));
  p_pc_last_r12: assert property (@(posedge clk) disable iff (rst) pc_en |=> ir_en);
  p_excl_r12: assert property (@(posedge clk) disable iff (rst)
    $countones({rf_wr, dmem_rd, dmem_wr}) <= 1);
  p_alu_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !res_en |-> (alu_op == ALU_ADD));
endmodule

// File: tb/tb_cyc_ctrl.sv
module tb_cyc_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic eq_flag = 1'b0;
  logic imem_rd, ir_en, a_en, b_en, res_en, dmem_rd, dmem_wr, rf_wr, dst_rd, wb_mem, pc_en, pc_sel;
  logic [2:0] alu_op;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cyc_ctrl dut (.clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .eq_flag(eq_flag),
    .imem_rd(imem_rd), .ir_en(ir_en), .a_en(a_en), .b_en(b_en), .alu_op(alu_op),
    .res_en(res_en), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .rf_wr(rf_wr),
    .dst_rd(dst_rd), .wb_mem(wb_mem), .pc_en(pc_en), .pc_sel(pc_sel));

  localparam logic [5:0] O_R = 6'b000000, O_ORI = 6'b001101, O_LW = 6'b100011,
                         O_SW = 6'b101011, O_BEQ = 6'b000100;

  // vector: imem_rd ir_en a_en b_en alu_op[3] res_en dmem_rd dmem_wr rf_wr dst_rd wb_mem pc_en pc_sel
  function automatic logic [14:0] mk(input logic im, ir, a, b, input logic [2:0] alu,
      input logic res, mr, mw, rw, dr, wm, pe, ps);
    return {im, ir, a, b, alu, res, mr, mw, rw, dr, wm, pe, ps};
  endfunction

  function automatic logic [2:0] fn_map(input logic [5:0] f);
    case (f)
      6'b100010: return 3'd1;
      6'b100100: return 3'd2;
      6'b100101: return 3'd3;
      6'b101010: return 3'd4;
      default:   return 3'd0;
    endcase
  endfunction

  function automatic int cycles(input logic [5:0] op);
    case (op)
      O_R, O_ORI, O_SW: return 4;
      O_LW: return 5;
      O_BEQ: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [14:0] expv(input logic [5:0] op, input logic [5:0] f,
      input logic eq, input int step);
    if (step == 0) return mk(1,1,0,0,3'd0,0,0,0,0,0,0,0,0);
    if (step == 1) return mk(0,0,1,1,3'd0,0,0,0,0,0,0,0,0);
    case (op)
      O_R:   return (step == 2) ? mk(0,0,0,0,fn_map(f),1,0,0,0,0,0,0,0)
                                : mk(0,0,0,0,3'd0,0,0,0,1,1,0,1,0);
      O_ORI: return (step == 2) ? mk(0,0,0,0,3'd3,1,0,0,0,0,0,0,0)
                                : mk(0,0,0,0,3'd0,0,0,0,1,0,0,1,0);
      O_LW:  return (step == 2) ? mk(0,0,0,0,3'd0,1,0,0,0,0,0,0,0)
                  : (step == 3) ? mk(0,0,0,0,3'd0,0,1,0,0,0,0,0,0)
                                : mk(0,0,0,0,3'd0,0,0,0,1,0,1,1,0);
      O_SW:  return (step == 2) ? mk(0,0,0,0,3'd0,1,0,0,0,0,0,0,0)
                                : mk(0,0,0,0,3'd0,0,0,1,0,0,0,1,0);
      O_BEQ: return mk(0,0,0,0,3'd0,0,0,0,0,0,0,1,eq);
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] op, input logic eq, input int step);
    if (step < 2) return "R2";
    case (op)
      O_R:   return (step == 2) ? "R4 R11" : "R4";
      O_ORI: return "R5";
      O_LW:  return "R6";
      O_SW:  return "R7";
      O_BEQ: return eq ? "R8" : "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [14:0] got();
    return {imem_rd, ir_en, a_en, b_en, alu_op, res_en, dmem_rd, dmem_wr, rf_wr, dst_rd, wb_mem, pc_en, pc_sel};
  endfunction

  task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Entered just after a falling edge with the sequencer in fetch; leaves at the next instruction's fetch.
  task automatic run_instr(input logic [5:0] op, input logic [5:0] f, input logic eq);
    int n = cycles(op);
    int pcs = 0;
    for (int s = 0; s < n; s++) begin
      if (s == 1) begin opcode = op; eq_flag = eq; end
      else begin opcode = 6'($urandom); eq_flag = 1'($urandom); end
      funct = (op == O_R && s == 2) ? f : 6'($urandom);
      #1;
      // R3: opcode/eq/funct are random outside the cycles that may use them.
      check(s == 1 ? tag_of(op, eq, s) : {"R3 ", tag_of(op, eq, s)}, got(), expv(op, f, eq, s));
      if (pc_en) pcs++;
      @(negedge clk);
    end
    n_chk++;
    if (pcs != ((n == 2) ? 0 : 1)) begin
      n_fail++;
      $display("FAIL R12: pc_en cycles %0d expected %0d for opcode %b", pcs, (n == 2) ? 0 : 1, op);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    logic [5:0] ops [6];
    logic [5:0] fns [6];
    void'($urandom(32'h1c0de5));
    ops = '{O_R, O_ORI, O_LW, O_SW, O_BEQ, 6'b111111};
    fns = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010, 6'b000111};
    repeat (3) @(negedge clk);
    #1 check("R1 during reset", got(), mk(1,1,0,0,3'd0,0,0,0,0,0,0,0,0));
    @(negedge clk);
    rst = 1'b0;
    #1 check("R1 after reset", got(), mk(1,1,0,0,3'd0,0,0,0,0,0,0,0,0));

    // directed: every class, every funct mapping, both branch outcomes, unknown opcodes
    for (int i = 0; i < 6; i++) run_instr(O_R, fns[i], 1'b0);
    run_instr(O_ORI, 6'b100010, 1'b1);
    run_instr(O_LW, 6'b000000, 1'b1);
    run_instr(O_SW, 6'b000000, 1'b1);
    run_instr(O_BEQ, 6'b000000, 1'b1);
    run_instr(O_BEQ, 6'b000000, 1'b0);
    run_instr(6'b111111, 6'b000000, 1'b1);
    run_instr(6'b000010, 6'b000000, 1'b0);

    // directed: reset while a load sits in its memory cycle
    opcode = O_LW;
    for (int s = 0; s < 3; s++) @(negedge clk);
    #1 check("R6 mid-load", got(), mk(0,0,0,0,3'd0,0,1,0,0,0,0,0,0));
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 check("R1 reset from memory state", got(), mk(1,1,0,0,3'd0,0,0,0,0,0,0,0,0));

    // random instruction mix
    for (int k = 0; k < 400; k++) begin
      logic [5:0] op = ops[$urandom_range(5)];
      if (op == 6'b111111) op = 6'($urandom);
      run_instr(op, ($urandom_range(3) == 0) ? 6'($urandom) : fns[$urandom_range(4)], 1'($urandom));
    end
    summary();
  end
endmodule